// File: doc/BRIEF.md
# Critical-Word-First Line Refill Controller

This controller runs the refill of one cache line after a miss. A line holds four words. The controller accepts a miss request that names the line and the word the processor is waiting for. It then fetches all four words from a memory port, one request at a time, and writes each returned word into the line buffer. The processor is released as soon as its own word arrives, while the rest of the line is still being filled.

There are two fill orders, and the requester picks one for each miss. In the default mode the missing word is fetched first, and the other words follow in wrap-around order. In the alternative mode the words are fetched from index 0 upward, and the processor is released when its word comes past. The memory port takes one word request at a time and answers after its own fixed latency. The bench models that latency as 4 cycles of address send, 56 cycles of access and 4 cycles of transfer. The line is marked valid only once all four words are in the buffer. While a fill is running, the controller stalls any further request.

Top module: `lineRefillCtrl`

## Requirements
- R1: After reset, `reqReady` is 1, and `memReqValid`, `lineWe`, `cpuValid` and `lineValid` are all 0.
- R2: When `reqEarly` is 0 at acceptance, the four memory requests carry word indices w, w+1, w+2, w+3 modulo 4, where w is `reqWord`. The word index is the low 2 bits of `memReqAddr`, and the requested line is in the bits above it.
- R3: When `reqEarly` is 1 at acceptance, the four memory requests carry word indices 0, 1, 2, 3 in that order.
- R4: In the cycle of each memory response, `lineWe` is 1, `lineWordIdx` is the index of the word that was requested, and `lineWdata` equals `memRespData`.
- R5: Each fill raises `cpuValid` for exactly one cycle. In that cycle `cpuData` is the data of the requested word.
- R6: In wrap-around mode, `cpuValid` comes with the first response of the fill. In sequential mode it comes with response number w+1.
- R7: `lineValid` rises only after all four words of the line have been written. It drops in the cycle after a new request is accepted.
- R8: While a fill is in progress, `reqReady` is 0. A request presented during the fill is not accepted and does not change the line being fetched.
- R9: At most one memory request is outstanding. The next request is issued only after the response to the previous one.
- R10: A change of `reqEarly` or `reqWord` during a fill does not change the fill order, or the word that is forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A miss request is presented |
| reqLine | input | LINE_W | Line address of the miss |
| reqWord | input | OFF_W | Index of the word the processor is waiting for |
| reqEarly | input | 1 | 1 = fetch in sequential order, 0 = requested word first |
| reqReady | output | 1 | Controller is idle and accepts a request |
| memReqValid | output | 1 | One-cycle word request to memory |
| memReqAddr | output | LINE_W+OFF_W | Line address in the upper bits, word index in the lower bits |
| memRespValid | input | 1 | Memory returns one word |
| memRespData | input | DATA_W | Returned word |
| lineWe | output | 1 | Write strobe to the line buffer |
| lineWordIdx | output | OFF_W | Word position written |
| lineWdata | output | DATA_W | Word written |
| lineValid | output | 1 | All words of the current line are present |
| cpuValid | output | 1 | One-cycle pulse forwarding the requested word |
| cpuData | output | DATA_W | Requested word |

## Verification
Fills run in wrap-around mode with the requested word at every position 0 to 3, so a wrap that starts from the wrong point or wraps at the wrong width shows up in the logged request order. The same positions are repeated in sequential mode, where the forwarding pulse must move from the first response to a later one; this separates forwarding by position from forwarding by index. A fill whose request inputs are changed part way through, together with a competing request, shows whether the mode, the word and the line are held from acceptance. Back-to-back fills show whether `lineValid` is cleared and set again in the right order.

// File: rtl/refillPkg.sv
package refillPkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT
  } refillStateT;

  typedef struct packed {
    logic latchReq;
    logic issue;
    logic wordDone;
    logic finish;
  } refillStrobeT;
endpackage

// File: rtl/refillCtrl.sv
module refillCtrl
  import refillPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         memRespValid,
  input  logic         lastWord,
  output refillStrobeT strobe,
  output logic         reqReady,
  output logic         busy
);
  refillStateT state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.latchReq = 1'b1;
          stateNext       = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        strobe.issue = 1'b1;
        stateNext    = ST_WAIT;
      end
      ST_WAIT: begin
        if (memRespValid) begin
          strobe.wordDone = 1'b1;
          if (lastWord) begin
            strobe.finish = 1'b1;
            stateNext     = ST_IDLE;
          end else begin
            stateNext = ST_ISSUE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign reqReady = (state == ST_IDLE);
  assign busy     = (state != ST_IDLE);

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issue |=> !strobe.issue) else $error("issue twice"); // R9
  AST_ISSUE_AFTER_RESP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue && $past(busy)) |-> $past(memRespValid)) else $error("early issue"); // R9
endmodule

// File: rtl/refillDatapath.sv
module refillDatapath
  import refillPkg::*;
#(
  parameter int WORDS  = 4,
  parameter int LINE_W = 8,
  parameter int DATA_W = 32,
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  refillStrobeT            strobe,
  input  logic                    busy,
  input  logic [LINE_W-1:0]       reqLine,
  input  logic [OFF_W-1:0]        reqWord,
  input  logic                    reqEarly,
  input  logic [DATA_W-1:0]       memRespData,
  output logic [LINE_W+OFF_W-1:0] memReqAddr,
  output logic                    lineWe,
  output logic [OFF_W-1:0]        lineWordIdx,
  output logic [DATA_W-1:0]       lineWdata,
  output logic                    lineValid,
  output logic                    cpuValid,
  output logic [DATA_W-1:0]       cpuData,
  output logic                    lastWord
);
  logic [LINE_W-1:0] lineReg;
  logic [OFF_W-1:0]  critReg;
  logic [OFF_W-1:0]  cntReg;
  logic              earlyReg;
  logic [WORDS-1:0]  maskReg;
  logic              sentReg;
  logic              lineValidReg;
  logic [OFF_W-1:0]  wordIdx;

  // Wrap-around order comes from the natural overflow of the OFF_W-bit sum
  assign wordIdx  = earlyReg ? cntReg : critReg + cntReg;
  assign lastWord = (cntReg == OFF_W'(WORDS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineReg      <= '0;
      critReg      <= '0;
      cntReg       <= '0;
      earlyReg     <= 1'b0;
      maskReg      <= '0;
      sentReg      <= 1'b0;
      lineValidReg <= 1'b0;
    end else if (strobe.latchReq) begin
      lineReg      <= reqLine;
      critReg      <= reqWord;
      earlyReg     <= reqEarly;
      cntReg       <= '0;
      maskReg      <= '0;
      sentReg      <= 1'b0;
      lineValidReg <= 1'b0;
    end else if (strobe.wordDone) begin
      cntReg           <= cntReg + 1'b1;
      maskReg[wordIdx] <= 1'b1;
      if (wordIdx == critReg) sentReg <= 1'b1;
      if (strobe.finish) lineValidReg <= 1'b1;
    end
  end

  assign memReqAddr  = {lineReg, wordIdx};
  assign lineWe      = strobe.wordDone;
  assign lineWordIdx = wordIdx;
  assign lineWdata   = memRespData;
  assign cpuValid    = strobe.wordDone && (wordIdx == critReg);
  assign cpuData     = memRespData;
  assign lineValid   = lineValidReg;

  AST_LINE_FULL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lineValid) |-> (maskReg == {WORDS{1'b1}})) else $error("partial line valid"); // R7
  AST_SINGLE_FORWARD: assert property (@(posedge clk) disable iff (!rstN)
    cpuValid |-> !sentReg) else $error("forwarded twice"); // R5
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    cpuValid |=> !cpuValid) else $error("long pulse"); // R5
  AST_LINE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(lineReg) && $stable(earlyReg) && $stable(critReg)))
    else $error("request changed mid-fill"); // R8
  AST_CWF_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (cpuValid && !earlyReg) |-> (cntReg == '0)) else $error("late forward"); // R6
endmodule

// File: rtl/lineRefillCtrl.sv
module lineRefillCtrl
  import refillPkg::*;
#(
  parameter int WORDS  = 4,
  parameter int LINE_W = 8,
  parameter int DATA_W = 32,
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic [LINE_W-1:0]       reqLine,
  input  logic [OFF_W-1:0]        reqWord,
  input  logic                    reqEarly,
  output logic                    reqReady,
  output logic                    memReqValid,
  output logic [LINE_W+OFF_W-1:0] memReqAddr,
  input  logic                    memRespValid,
  input  logic [DATA_W-1:0]       memRespData,
  output logic                    lineWe,
  output logic [OFF_W-1:0]        lineWordIdx,
  output logic [DATA_W-1:0]       lineWdata,
  output logic                    lineValid,
  output logic                    cpuValid,
  output logic [DATA_W-1:0]       cpuData
);
  refillStrobeT strobe;
  logic         lastWord;
  logic         busy;

  refillCtrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .memRespValid (memRespValid),
    .lastWord     (lastWord),
    .strobe       (strobe),
    .reqReady     (reqReady),
    .busy         (busy)
  );

  refillDatapath #(
    .WORDS  (WORDS),
    .LINE_W (LINE_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .busy        (busy),
    .reqLine     (reqLine),
    .reqWord     (reqWord),
    .reqEarly    (reqEarly),
    .memRespData (memRespData),
    .memReqAddr  (memReqAddr),
    .lineWe      (lineWe),
    .lineWordIdx (lineWordIdx),
    .lineWdata   (lineWdata),
    .lineValid   (lineValid),
    .cpuValid    (cpuValid),
    .cpuData     (cpuData),
    .lastWord    (lastWord)
  );

  assign memReqValid = strobe.issue;
endmodule

// File: tb/lineRefillCtrl_bench.sv
module lineRefillCtrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LINE_W = 8;
  localparam int DATA_W = 32;
  localparam int OFF_W  = 2;
  localparam int MEM_LAT = 4 + 56 + 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [LINE_W-1:0] reqLine = '0;
  logic [OFF_W-1:0] reqWord = '0;
  logic reqEarly = 1'b0;
  logic reqReady, memReqValid, lineWe, lineValid, cpuValid;
  logic [LINE_W+OFF_W-1:0] memReqAddr;
  logic memRespValid = 1'b0;
  logic [DATA_W-1:0] memRespData = '0;
  logic [OFF_W-1:0] lineWordIdx;
  logic [DATA_W-1:0] lineWdata, cpuData;

  int total = 0;
  int bad = 0;

  lineRefillCtrl u_lineRefillCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLine(reqLine),
    .reqWord(reqWord), .reqEarly(reqEarly), .reqReady(reqReady),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRespValid(memRespValid), .memRespData(memRespData),
    .lineWe(lineWe), .lineWordIdx(lineWordIdx), .lineWdata(lineWdata),
    .lineValid(lineValid), .cpuValid(cpuValid), .cpuData(cpuData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DATA_W-1:0] memWord(input logic [LINE_W+OFF_W-1:0] a);
    return 32'hA500_0000 | (32'(a) * 32'd3 + 32'd7);
  endfunction

  // Memory model: one request at a time, fixed latency
  logic pend = 1'b0;
  int waitCnt = 0;
  logic [LINE_W+OFF_W-1:0] pendAddr = '0;
  always @(posedge clk) begin
    memRespValid <= 1'b0;
    if (!rstN) pend <= 1'b0;
    else begin
      if (pend) begin
        if (waitCnt == 0) begin
          memRespValid <= 1'b1;
          memRespData  <= memWord(pendAddr);
          pend <= 1'b0;
        end else waitCnt <= waitCnt - 1;
      end
      if (memReqValid) begin
        pend <= 1'b1;
        pendAddr <= memReqAddr;
        waitCnt <= MEM_LAT - 2;
      end
    end
  end

  // Monitor, sampled on the falling edge
  int reqCnt, wrCnt, cpuCnt, cpuPos, dataErr, earlyValid, doubleReq;
  logic [OFF_W-1:0] reqIdx [0:7];
  logic [LINE_W-1:0] reqLn [0:7];
  logic [DATA_W-1:0] cpuSeen;
  logic prevReq = 1'b0;

  task automatic clearLog();
    reqCnt = 0; wrCnt = 0; cpuCnt = 0; cpuPos = -1; dataErr = 0;
    earlyValid = 0; doubleReq = 0; cpuSeen = '0;
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (memReqValid) begin
        if (reqCnt < 8) begin
          reqIdx[reqCnt] = memReqAddr[OFF_W-1:0];
          reqLn[reqCnt]  = memReqAddr[LINE_W+OFF_W-1:OFF_W];
        end
        if (pend || prevReq) doubleReq++;
        reqCnt++;
      end
      prevReq = memReqValid;
      if (lineWe) begin
        if (lineWdata !== memRespData || !memRespValid) dataErr++;
        if (reqCnt > 0 && reqCnt <= 8 && lineWordIdx !== reqIdx[reqCnt-1]) dataErr++;
        if (cpuValid) begin cpuPos = wrCnt; cpuSeen = cpuData; end
        wrCnt++;
      end
      if (cpuValid) cpuCnt++;
      if (lineValid && wrCnt < 4 && reqCnt > 0) earlyValid++;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic startFill(input logic [LINE_W-1:0] ln, input logic [OFF_W-1:0] w, input logic early);
    clearLog();
    @(negedge clk);
    reqValid = 1'b1; reqLine = ln; reqWord = w; reqEarly = early;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitDone();
    int n = 0;
    while (!lineValid && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic checkFill(input logic [LINE_W-1:0] ln, input int w, input logic early);
    logic [OFF_W-1:0] e;
    check(reqCnt == 4, early ? "R3" : "R2", "request count", reqCnt, 4);
    for (int k = 0; k < 4 && k < reqCnt; k++) begin
      e = early ? OFF_W'(k) : OFF_W'(w + k);
      check(reqIdx[k] == e, early ? "R3" : "R2", "word order", int'(reqIdx[k]), int'(e));
      check(reqLn[k] == ln, "R8", "line address", int'(reqLn[k]), int'(ln));
    end
    check(dataErr == 0, "R4", "line write mismatches", dataErr, 0);
    check(cpuCnt == 1, "R5", "forward pulse cycles", cpuCnt, 1);
    check(cpuSeen == memWord({ln, OFF_W'(w)}), "R5", "forwarded data", int'(cpuSeen),
          int'(memWord({ln, OFF_W'(w)})));
    check(cpuPos == (early ? w : 0), "R6", "forward position", cpuPos, early ? w : 0);
    check(earlyValid == 0 && lineValid && wrCnt == 4, "R7", "valid before full", earlyValid, 0);
    check(doubleReq == 0, "R9", "overlapping requests", doubleReq, 0);
  endtask

  task automatic testReset();
    check(reqReady == 1'b1, "R1", "reqReady", int'(reqReady), 1);
    check(!memReqValid && !lineWe && !cpuValid, "R1", "strobes idle", int'(memReqValid), 0);
    check(lineValid == 1'b0, "R1", "lineValid", int'(lineValid), 0);
  endtask

  task automatic testWrap(input int w);
    logic [LINE_W-1:0] ln = LINE_W'(8'h30 + w);
    startFill(ln, OFF_W'(w), 1'b0);
    check(lineValid == 1'b0, "R7", "lineValid cleared on accept", int'(lineValid), 0);
    waitDone();
    checkFill(ln, w, 1'b0);
  endtask

  task automatic testSeq(input int w);
    logic [LINE_W-1:0] ln = LINE_W'(8'h50 + w);
    startFill(ln, OFF_W'(w), 1'b1);
    waitDone();
    checkFill(ln, w, 1'b1);
  endtask

  task automatic testHold();
    logic [LINE_W-1:0] ln = 8'h77;
    int accepted = 0;
    startFill(ln, 2'd3, 1'b0);
    repeat (20) @(negedge clk);
    reqValid = 1'b1; reqLine = 8'h11; reqWord = 2'd1; reqEarly = 1'b1;
    check(reqReady == 1'b0, "R8", "reqReady during fill", int'(reqReady), 0);
    repeat (100) begin
      @(negedge clk);
      if (reqReady && !lineValid) accepted++;
    end
    reqValid = 1'b0;
    waitDone();
    check(accepted == 0, "R8", "accepted during fill", accepted, 0);
    checkFill(ln, 3, 1'b0); // R10: order and forwarded word from acceptance
    reqEarly = 1'b0;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        @(negedge clk);
        testReset();
        for (int w = 0; w < 4; w++) testWrap(w);
        for (int w = 0; w < 4; w++) testSeq(w);
        testHold();
      end
      begin
        repeat (150000) @(negedge clk);
        check(1'b0, "WDOG", "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule